// File: doc/BRIEF.md
# Multi-format serial word transmitter

This block turns one 8-bit byte into a serial frame each time it is asked to. A 3-bit format code picks the frame shape. Code 0 is a synchronous shift mode: only the eight data bits go out, and a gated clock pulses once for each bit. Code 2 is a plain asynchronous frame. Codes 4 and 5 add an even or an odd parity bit. Code 6 adds a type bit that marks the word as an address or as data on a shared multidrop line. Codes 1, 3 and 7 are reserved. A request that carries one of them is refused and raises a one-cycle error pulse.

Bit timing comes from an external bit-rate tick. The line changes only on a tick while a frame is in flight, so one bit lasts one tick interval. The first bit is driven out straight after the request is accepted. The caller waits for `busy` to drop before it issues the next request. Any start strobe that arrives while a frame is in flight is dropped.

Top module: `txfmt_top`

## Requirements
- R1: After reset, `busy` is 0, `bad_mode` is 0, `sclk` is 0 and `sdata` is 1.
- R2: Format code 0 sends exactly eight bits, data bit 0 first, with no start bit and no stop bit.
- R3: In code 0, `sclk` pulses high for one clock cycle after each tick that ends a bit, eight pulses per frame. In every other format `sclk` stays 0.
- R4: Format code 2 sends 10 bits: a 0 start bit, data bits 0 to 7, then a 1 stop bit.
- R5: Format code 4 sends 11 bits: start, data bits 0 to 7, a parity bit, then stop. The parity bit makes the number of ones across data plus parity even.
- R6: Format code 5 sends 11 bits in the same order. The parity bit is 1 exactly when the data holds an even number of ones, so the total count of ones is odd.
- R7: Format code 6 sends 11 bits: start, data bits 0 to 7, the value of `type_bit` captured at the request, then stop.
- R8: A start with format code 1, 3 or 7 while idle sends nothing. It leaves `busy` at 0 and drives `bad_mode` high for exactly one cycle, the cycle after the request.
- R9: `busy` rises the cycle after an accepted start. It stays high until the cycle after the tick that ends the last bit. A start while `busy` is high has no effect on the frame in flight.
- R10: `sdata` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Format code, sampled with `start` |
| data_in | input | 8 | Byte to send, sampled with `start` |
| type_bit | input | 1 | Address/data type bit for code 6, sampled with `start` |
| start | input | 1 | Request strobe |
| bit_tick | input | 1 | One-cycle bit-rate tick |
| busy | output | 1 | Frame in flight |
| sdata | output | 1 | Serial data line |
| sclk | output | 1 | Gated shift clock for code 0 |
| bad_mode | output | 1 | One-cycle pulse on a refused reserved code |

## Verification
The bench checks parity on bytes whose count of ones is even and on bytes whose count of ones is odd. A design that swapped even and odd parity, or computed parity over the wrong bits, would send the wrong parity bit. It checks that code 0 sends neither a start nor a stop bit and that `sclk` gives exactly eight pulses there and none in any other format. An off-by-one bit counter would show up as a frame with the wrong bit count. The bench also sends requests with reserved codes and strobes `start` in the middle of a frame. A design that accepted either request would corrupt the line or hold `busy` too long. It also checks that the type bit is the value captured at the request, after the input has been changed. A design that read the live input would send the changed value.

// File: rtl/txfmt_pkg.sv
package txfmt_pkg;
  typedef logic [2:0] fmt_code_t;
  localparam fmt_code_t FMT_SYNC  = 3'd0;
  localparam fmt_code_t FMT_PLAIN = 3'd2;
  localparam fmt_code_t FMT_EVEN  = 3'd4;
  localparam fmt_code_t FMT_ODD   = 3'd5;
  localparam fmt_code_t FMT_MDROP = 3'd6;
endpackage

// File: rtl/txfmt_frame.sv
module txfmt_frame
  import txfmt_pkg::*;
#(
  parameter int DW = 8,
  localparam int FW = DW + 3,
  localparam int LW = $clog2(FW + 1)
) (
  input  fmt_code_t       code,
  input  logic [DW-1:0]   data,
  input  logic            tbit,
  output logic [FW-1:0]   frame,
  output logic [LW-1:0]   len,
  output logic            legal,
  output logic            sync
);
  logic par_even;
  assign par_even = ^data;

  always_comb begin
    frame = '1;
    len   = LW'(FW);
    legal = 1'b1;
    sync  = 1'b0;
    unique case (code)
      FMT_SYNC: begin
        frame = {3'b111, data};
        len   = LW'(DW);
        sync  = 1'b1;
      end
      FMT_PLAIN: begin
        frame = {2'b11, data, 1'b0};
        len   = LW'(DW + 2);
      end
      FMT_EVEN:  frame = {1'b1, par_even, data, 1'b0};
      FMT_ODD:   frame = {1'b1, ~par_even, data, 1'b0};
      FMT_MDROP: frame = {1'b1, tbit, data, 1'b0};
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/txfmt_shifter.sv
module txfmt_shifter #(
  parameter int DW = 8,
  localparam int FW = DW + 3,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] len,
  input  logic          sync,
  input  logic          tick,
  output logic          busy,
  output logic          sdata,
  output logic          sclk
);
  logic [FW-1:0] sh_q;
  logic [LW-1:0] cnt_q;
  logic          sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      sync_q <= 1'b0;
      busy   <= 1'b0;
      sdata  <= 1'b1;
      sclk   <= 1'b0;
    end else begin
      sclk <= 1'b0;
      if (load) begin
        sh_q   <= frame;
        cnt_q  <= len;
        sync_q <= sync;
        busy   <= 1'b1;
        sdata  <= frame[0];
      end else if (busy && tick) begin
        sclk <= sync_q;
        if (cnt_q == LW'(1)) begin
          busy  <= 1'b0;
          sdata <= 1'b1;
          cnt_q <= '0;
        end else begin
          sh_q  <= {1'b1, sh_q[FW-1:1]};
          sdata <= sh_q[1];
          cnt_q <= cnt_q - LW'(1);
        end
      end
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LW'(FW));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !tick |=> busy);
  // R3
  sclk_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $past(busy) && $past(tick) && $past(sync_q));
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sdata);
endmodule

// File: rtl/txfmt_top.sv
module txfmt_top
  import txfmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    fmt,
  input  logic [DW-1:0] data_in,
  input  logic          type_bit,
  input  logic          start,
  input  logic          bit_tick,
  output logic          busy,
  output logic          sdata,
  output logic          sclk,
  output logic          bad_mode
);
  localparam int FW = DW + 3;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] frame;
  logic [LW-1:0] len;
  logic          legal, sync, accept;

  txfmt_frame #(.DW(DW)) u_frame (
    .code(fmt), .data(data_in), .tbit(type_bit),
    .frame(frame), .len(len), .legal(legal), .sync(sync)
  );

  assign accept = start && !busy && legal;

  txfmt_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .frame(frame), .len(len),
    .sync(sync), .tick(bit_tick), .busy(busy), .sdata(sdata), .sclk(sclk)
  );

  always_ff @(posedge clk) begin
    if (rst) bad_mode <= 1'b0;
    else     bad_mode <= start && !busy && !legal;
  end

  // R8
  bad_idle_chk: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> !busy && !$past(busy));
  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/txfmt_top_test.sv
module txfmt_top_test;
  logic clk = 0, rst = 1;
  logic [2:0] fmt = 0;
  logic [7:0] din = 0;
  logic tb = 0, start = 0, tick = 0;
  logic busy, sdata, sclk, bad_mode;
  int total = 0, bad = 0, tper = 3;
  bit done = 0;
  logic [15:0] cap;
  int ncap = 0, nclk = 0;

  always #5 clk = ~clk;

  txfmt_top uut (.clk(clk), .rst(rst), .fmt(fmt), .data_in(din), .type_bit(tb),
    .start(start), .bit_tick(tick), .busy(busy), .sdata(sdata), .sclk(sclk),
    .bad_mode(bad_mode));

  initial begin : tickgen
    int c = 0;
    forever begin
      @(posedge clk); #1;
      tick = (c == 0);
      c = (c + 1 >= tper) ? 0 : c + 1;
    end
  end

  always @(negedge clk) if (!rst) begin
    if (tick && busy) begin
      if (ncap < 16) cap[ncap] = sdata;
      ncap++;
    end
    if (sclk) nclk++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] f);
    if (f == 0) return 8;
    if (f == 2) return 10;
    return 11;
  endfunction

  function automatic logic [15:0] exp_bits(input logic [2:0] f, input logic [7:0] d,
                                          input logic t);
    logic [15:0] v = '0;
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    if (f == 0) begin
      v[7:0] = d;
    end else begin
      v[0] = 1'b0;
      v[8:1] = d;
      if (f == 2) v[9] = 1'b1;
      else begin
        if (f == 4) v[9] = (ones % 2 == 1);
        else if (f == 5) v[9] = (ones % 2 == 0);
        else v[9] = t;
        v[10] = 1'b1;
      end
    end
    return v;
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      0: return "R2";
      2: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic send(input logic [2:0] f, input logic [7:0] d, input logic t,
                      input bit poke);
    int n = exp_len(f);
    logic [15:0] e = exp_bits(f, d, t);
    logic [15:0] m = (16'h1 << n) - 1;
    ncap = 0; nclk = 0;
    @(posedge clk); #1 fmt = f; din = d; tb = t; start = 1;
    @(posedge clk); #1 start = 0; din = ~d; tb = ~t;
    @(negedge clk);
    chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 start = 1; fmt = 3'd2; din = 8'h5A;
      @(posedge clk); #1 start = 0;
    end
    forever begin
      @(negedge clk); #1;
      if (!busy) break;
    end
    chk(ncap == n, req_of(f), "bit count", ncap, n);
    chk((cap & m) == e, req_of(f), "frame bits", int'(cap & m), int'(e));
    chk(nclk == ((f == 0) ? 8 : 0), "R3", "sclk pulses", nclk, (f == 0) ? 8 : 0);
    chk(sdata === 1'b1, "R10", "idle line", sdata, 1);
    if (poke) chk(bad_mode === 1'b0, "R9", "no error on busy start", bad_mode, 0);
  endtask

  task automatic rsv(input logic [2:0] f);
    ncap = 0; nclk = 0;
    @(posedge clk); #1 fmt = f; start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(bad_mode === 1'b1, "R8", "error pulse", bad_mode, 1);
    chk(busy === 1'b0, "R8", "stays idle", busy, 0);
    @(negedge clk);
    chk(bad_mode === 1'b0, "R8", "pulse one cycle", bad_mode, 0);
    repeat (3 * tper) @(negedge clk);
    chk(busy === 1'b0 && sdata === 1'b1 && ncap == 0 && nclk == 0, "R8",
        "nothing sent", {busy, sdata}, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] legal_codes [5] = '{3'd0, 3'd2, 3'd4, 3'd5, 3'd6};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(busy === 0 && bad_mode === 0 && sclk === 0 && sdata === 1, "R1",
        "reset state", {busy, bad_mode, sclk, sdata}, 4'b0001);
    // directed: parity on even and odd ones counts
    send(3'd4, 8'h03, 0, 0);  // R5 even count
    send(3'd4, 8'h07, 0, 0);  // R5 odd count
    send(3'd5, 8'h03, 0, 0);  // R6 even count
    send(3'd5, 8'h01, 0, 0);  // R6 odd count
    send(3'd6, 8'hA5, 1, 0);  // R7 type one
    send(3'd6, 8'hA5, 0, 0);  // R7 type zero
    send(3'd0, 8'h81, 0, 0);  // R2, R3
    send(3'd2, 8'h00, 0, 1);  // R4 with start while busy (R9)
    send(3'd0, 8'hFF, 0, 1);  // R2 with start while busy (R9)
    rsv(3'd1); rsv(3'd3); rsv(3'd7);
    for (int i = 0; i < 40; i++) begin
      tper = 2 + ($urandom % 4);
      send(legal_codes[$urandom % 5], 8'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule